// File: doc/BRIEF.md
# DMA Page-Table Address Translator

This block sits between a DMA-capable device and system memory. It turns a 32-bit device-side address into a physical address using a single-level page table that lives in ordinary memory. Pages are 4 KiB. Each table entry is 8 bytes: a frame word, followed by a word this block never reads. Software programs two registers through a narrow write port: a table origin and a table length in bytes. The top bit of the origin is ignored when entry addresses are formed.

A device presents one address at a time on a valid/ready request channel. The block checks the page number against the table length. If the page is in range, it fetches the frame word through a memory-master port that has valid/ready request and response channels. It then returns the translated address, or a fault, on a valid/ready response channel. A page beyond the table, or an entry read that comes back with an error, gives a fault with an all-zero address. Only one translation is outstanding at any time.

Top module: `pt_xlate`

## Requirements
- R1: After reset, origin and length are zero. `req_ready` is high, and `rsp_valid` and `mem_req_valid` are low. Every translation faults until software programs the registers.
- R2: A request with page number `addr[31:12]` not below `length >> 3` faults. Its response has `rsp_fault`=1 and `rsp_addr`=0, and no memory read is issued for it.
- R3: For an in-range page, the entry is read at `(origin & 32'h7FFF_FFFF) + page*8`, wrapping at 32 bits.
- R4: A successful fetch returns `rsp_fault`=0 and `rsp_addr` = `{frame[31:12], addr[11:0]}`. The low 12 bits of the frame word are discarded.
- R5: An entry read whose response has `mem_rsp_err`=1 yields `rsp_fault`=1 and `rsp_addr`=0.
- R6: Only one translation is in flight. `req_ready` is low from the cycle after acceptance until the response handshake completes.
- R7: While `rsp_valid` is high and `rsp_ready` is low, the response holds its values. While `mem_req_valid` is high and `mem_req_ready` is low, the memory request holds its address.
- R8: A register write in the same cycle as a request acceptance does not affect that request. The request uses the values from before the write, and the next request sees the new value.
- R9: `cfg_sel` selects 0 = origin and 1 = length. Writes with `cfg_sel` 2 (table invalidate) or 3 are accepted and change no translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 origin, 1 length, 2 invalidate, 3 spare) |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Device-side address |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer accepts result |
| rsp_addr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 1 | Translation failed |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the frame word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Block accepts read data |
| mem_rsp_data | input | 32 | Frame word |
| mem_rsp_err | input | 1 | Read failed |

## Verification
Two things can land on the same clock edge: a register write and the acceptance of a translation request. In that case the range check and entry address must come from the register values before the write. The bench creates this overlap on purpose by raising `cfg_we` in the exact cycle it knows `req_ready` is high. It includes cases where the write changes the outcome, such as a zero length becoming large. It then expects the old-value result for that request and the new-value result for the request that follows. The random phase also overlaps writes with acceptances, and it stalls the memory and response channels at random.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;
  parameter int unsigned AW          = 32;
  parameter int unsigned PAGE_SHIFT  = 12;
  parameter int unsigned ENTRY_SHIFT = 3;
  localparam int unsigned IDX_W      = AW - PAGE_SHIFT;

  typedef enum logic [1:0] {
    CFG_ORIGIN = 2'd0,
    CFG_LENGTH = 2'd1,
    CFG_INVAL  = 2'd2,
    CFG_SPARE  = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MREQ  = 2'd1,
    ST_MWAIT = 2'd2,
    ST_RESP  = 2'd3
  } walk_st_e;

  function automatic logic [IDX_W-1:0] page_index(input logic [AW-1:0] a);
    return a[AW-1:PAGE_SHIFT];
  endfunction

  function automatic logic page_in_table(input logic [IDX_W-1:0] idx,
                                         input logic [AW-1:0] len);
    logic [AW-1:0] n_entries;
    n_entries = len >> ENTRY_SHIFT;
    return {{PAGE_SHIFT{1'b0}}, idx} < n_entries;
  endfunction

  function automatic logic [AW-1:0] entry_addr(input logic [AW-1:0] origin,
                                               input logic [IDX_W-1:0] idx);
    logic [AW-1:0] o;
    o = origin;
    o[AW-1] = 1'b0;
    return o + ({{PAGE_SHIFT{1'b0}}, idx} << ENTRY_SHIFT);
  endfunction

  function automatic logic [AW-1:0] phys_addr(input logic [AW-1:0] frame,
                                              input logic [PAGE_SHIFT-1:0] off);
    return {frame[AW-1:PAGE_SHIFT], off};
  endfunction
endpackage

// File: rtl/pt_xlate_cfg.sv
module pt_xlate_cfg
  import pt_xlate_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] origin_q,
  output logic [AW-1:0] length_q
);
  logic wr_origin, wr_length, wr_other;
  assign wr_origin = cfg_we && (cfg_sel_e'(cfg_sel) == CFG_ORIGIN);
  assign wr_length = cfg_we && (cfg_sel_e'(cfg_sel) == CFG_LENGTH);
  assign wr_other  = cfg_we && !wr_origin && !wr_length;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      origin_q <= '0;
      length_q <= '0;
    end else begin
      if (wr_origin) origin_q <= cfg_wdata;
      if (wr_length) length_q <= cfg_wdata;
    end
  end

  // R9
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_other |=> ($stable(origin_q) && $stable(length_q)));
endmodule

// File: rtl/pt_xlate_calc.sv
module pt_xlate_calc
  import pt_xlate_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] origin,
  input  logic [AW-1:0] length,
  output logic          in_range,
  output logic [AW-1:0] ent_addr
);
  logic [IDX_W-1:0] idx;
  assign idx      = page_index(addr);
  assign in_range = page_in_table(idx, length);
  assign ent_addr = entry_addr(origin, idx);
endmodule

// File: rtl/pt_xlate_walk.sv
module pt_xlate_walk
  import pt_xlate_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          in_range,
  input  logic [AW-1:0] ent_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_fault,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [AW-1:0] mem_rsp_data,
  input  logic          mem_rsp_err
);
  walk_st_e              st;
  logic [PAGE_SHIFT-1:0] off_q;
  logic                  accept, fetch_done, fetch_bad, rsp_done;

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_MREQ);
  assign mem_rsp_ready = (st == ST_MWAIT);
  assign rsp_valid     = (st == ST_RESP);

  assign accept     = req_valid && req_ready;
  assign fetch_done = mem_rsp_valid && mem_rsp_ready;
  assign fetch_bad  = fetch_done && mem_rsp_err;
  assign rsp_done   = rsp_valid && rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      off_q        <= '0;
      mem_req_addr <= '0;
      rsp_addr     <= '0;
      rsp_fault    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          off_q <= req_addr[PAGE_SHIFT-1:0];
          if (in_range) begin
            mem_req_addr <= ent_addr;
            st           <= ST_MREQ;
          end else begin
            rsp_addr  <= '0;
            rsp_fault <= 1'b1;
            st        <= ST_RESP;
          end
        end
        ST_MREQ: if (mem_req_ready) st <= ST_MWAIT;
        ST_MWAIT: if (fetch_done) begin
          rsp_fault <= mem_rsp_err;
          rsp_addr  <= mem_rsp_err ? '0 : phys_addr(mem_rsp_data, off_q);
          st        <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R6
  busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> !req_ready);
  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)));
  // R7
  mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R2
  out_of_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_range) |=> (rsp_valid && rsp_fault && rsp_addr == '0 && !mem_req_valid));
  // R5
  fetch_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_bad |=> (rsp_valid && rsp_fault && rsp_addr == '0));
  // R4
  frame_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_done && !mem_rsp_err) |=>
      (!rsp_fault && rsp_addr[AW-1:PAGE_SHIFT] == $past(mem_rsp_data[AW-1:PAGE_SHIFT])));
endmodule

// File: rtl/pt_xlate.sv
module pt_xlate
  import pt_xlate_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_fault,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [AW-1:0] mem_rsp_data,
  input  logic          mem_rsp_err
);
  logic [AW-1:0] origin_q, length_q, ent_addr;
  logic          in_range;

  pt_xlate_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .origin_q(origin_q), .length_q(length_q)
  );

  pt_xlate_calc u_calc (
    .addr(req_addr), .origin(origin_q), .length(length_q),
    .in_range(in_range), .ent_addr(ent_addr)
  );

  pt_xlate_walk u_walk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .in_range(in_range), .ent_addr(ent_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (req_ready && !rsp_valid && !mem_req_valid));
endmodule

// File: tb/pt_xlate_tb_top.sv
`timescale 1ns/1ps
module pt_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_addr;
  logic        rsp_fault;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] m_origin = '0, m_length = '0, exp_ent = '0;
  bit err_inject = 1'b0;
  int mem_cnt = 0;

  always #2.5 clk = ~clk;

  pt_xlate dut_i (.*);

  function automatic logic [31:0] frame_of(input logic [31:0] e);
    return (e * 32'h9E37_79B1) + 32'h0000_01F3;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    bit          last_mreq = 1'b0, last_mrsp = 1'b0, pend = 1'b0;
    int          dly = 0;
    logic [31:0] rec = '0;
    forever begin
      @(negedge clk);
      if (last_mrsp) mem_rsp_valid = 1'b0;
      if (last_mreq) begin
        mem_cnt++;
        chk(rec == exp_ent, "R3 entry address", rec, exp_ent);
        pend = 1'b1;
        dly  = int'($urandom % 3);
      end
      if (pend && !mem_rsp_valid) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = frame_of(rec);
          mem_rsp_err   = err_inject;
          pend = 1'b0;
        end else dly--;
      end
      mem_req_ready = ($urandom % 2) == 0;
      #1;
      last_mreq = mem_req_valid && mem_req_ready;
      last_mrsp = mem_rsp_valid && mem_rsp_ready;
      rec       = mem_req_addr;
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 2'd0) m_origin = d;
    if (sel == 2'd1) m_length = d;
  endtask

  task automatic xlate(input logic [31:0] a, input bit with_cfg,
                       input logic [1:0] sel, input logic [31:0] d, input string req);
    logic [31:0] idx, exp_addr, p_addr;
    bit ok, exp_fault, seen, p_fault;
    int n0;
    idx = a >> 12;
    ok  = idx < (m_length >> 3);
    exp_ent = (m_origin & 32'h7FFF_FFFF) + (idx << 3);
    exp_fault = !ok || err_inject;
    exp_addr  = exp_fault ? 32'h0 : ((frame_of(exp_ent) & 32'hFFFF_F000) | {20'h0, a[11:0]});
    n0 = mem_cnt;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = a;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (with_cfg) begin cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d; end
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b0;
    if (with_cfg && sel == 2'd0) m_origin = d;
    if (with_cfg && sel == 2'd1) m_length = d;
    #1;
    chk(!req_ready, "R6 busy after accept", {31'h0, req_ready}, 32'h0);
    seen = 1'b0; p_addr = '0; p_fault = 1'b0;
    forever begin
      @(negedge clk);
      rsp_ready = ($urandom % 3) != 0;
      #1;
      if (rsp_valid) begin
        if (seen) begin
          chk(rsp_addr == p_addr, "R7 rsp hold", rsp_addr, p_addr);
          chk(rsp_fault == p_fault, "R7 fault hold", {31'h0, rsp_fault}, {31'h0, p_fault});
        end
        seen = 1'b1; p_addr = rsp_addr; p_fault = rsp_fault;
        chk(!req_ready, "R6 busy while rsp", {31'h0, req_ready}, 32'h0);
        if (rsp_ready) begin
          chk(rsp_addr == exp_addr, req, rsp_addr, exp_addr);
          chk(rsp_fault == exp_fault, req, {31'h0, rsp_fault}, {31'h0, exp_fault});
          break;
        end
      end
    end
    if (!ok) chk(mem_cnt == n0, "R2 no fetch", mem_cnt, n0);
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    begin : wdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset outputs",
        {29'h0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
    xlate(32'h0000_1234, 0, 0, 0, "R1 unprogrammed faults");
    // R3: top origin bit masked
    cfg_write(2'd0, 32'h8000_1000);
    cfg_write(2'd1, 32'd128);
    xlate(32'h0000_0ABC, 0, 0, 0, "R4 first page");
    xlate(32'h0000_FFFF, 0, 0, 0, "R4 last page in table");
    xlate(32'h0001_0000, 0, 0, 0, "R2 first page past table");
    xlate(32'hFFFF_FFFF, 0, 0, 0, "R2 top address");
    cfg_write(2'd1, 32'd7);
    xlate(32'h0000_0010, 0, 0, 0, "R2 length below one entry");
    cfg_write(2'd1, 32'd8);
    xlate(32'h0000_0010, 0, 0, 0, "R4 single entry");
    xlate(32'h0000_1010, 0, 0, 0, "R2 past single entry");
    cfg_write(2'd1, 32'd4096);
    err_inject = 1'b1;
    xlate(32'h0003_0777, 0, 0, 0, "R5 fetch error");
    err_inject = 1'b0;
    cfg_write(2'd2, 32'hFFFF_FFFF);
    cfg_write(2'd3, 32'h0000_0000);
    xlate(32'h0003_0777, 0, 0, 0, "R9 ignored selects");
    cfg_write(2'd1, 32'd0);
    xlate(32'h0000_0123, 1, 2'd1, 32'h0001_0000, "R8 old length used");
    xlate(32'h0000_0123, 0, 0, 0, "R8 new length seen");
    xlate(32'h0000_2456, 1, 2'd0, 32'h0040_0000, "R8 old origin used");
    xlate(32'h0000_2456, 0, 0, 0, "R8 new origin seen");
    for (int i = 0; i < 200; i++) begin
      logic [31:0] a, n;
      bit wc;
      if ($urandom % 8 == 0) cfg_write(2'd0, $urandom);
      if ($urandom % 8 == 0) cfg_write(2'd1, $urandom % 32'h0002_0000);
      err_inject = ($urandom % 8) == 0;
      n = m_length >> 3;
      case ($urandom % 3)
        0: a = ((n == 0 ? 32'h0 : n - 1) << 12) | ($urandom & 32'hFFF);
        1: a = (n << 12) | ($urandom & 32'hFFF);
        default: a = $urandom;
      endcase
      wc = ($urandom % 5) == 0;
      xlate(a, wc, 2'($urandom % 4), (wc ? $urandom % 32'h0002_0000 : 32'h0),
            "R4 random translation");
    end
    err_inject = 1'b0;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule